// File: doc/BRIEF.md
# System Tick Countdown Timer

A 24-bit down-counter that gives a processor subsystem a periodic time base. Software programs a reload value and enables counting; the counter then steps down once per selected tick and, on the tick after it reaches zero, starts again from the reload value. Each pass from one to zero sets a sticky count flag. The flag can also drive an interrupt line.

Each tick is either every core clock cycle or a single-cycle strobe from a slower reference source. A read-only calibration word is fixed at build time from the reference frequency. It gives the number of reference ticks in 10 ms, a flag for a count that is not exact, and a flag for when no reference exists at all. A small synchronous port provides access at four word offsets:
- 0x0: control and status
- 0x4: reload value
- 0x8: current count
- 0xC: calibration word

Top module: `tick_down_timer`

## Requirements
- R1: After reset the control word reads 0, except that bit 2 reads 1 when no reference is built in. The reload and current registers read 0 and `irq_o` is low.
- R2: Only control bits 2:0 are stored: bit 0 enables counting, bit 1 enables the interrupt and bit 2 selects the tick source. Bit 16 reads the count flag. All other control bits read 0.
- R3: While bit 0 is 1, each tick lowers the count by one. A tick is every clock cycle when bit 2 is 1, and a cycle with `ref_tick_i` high when bit 2 is 0. While bit 0 is 0 the count holds.
- R4: A tick that finds the count at 0 loads the reload value. With a reload value of 0, the count stays at 0.
- R5: A tick that moves the count from 1 to 0 sets the count flag. `irq_o` is high whenever both the flag and control bit 1 are 1.
- R6: A read strobe at offset 0x0 clears the flag. If the flag is set by a tick in the same cycle, the set wins.
- R7: Any write to offset 0x8, whatever the data, clears both the count and the flag. This write takes priority over a tick in the same cycle.
- R8: With a reference present, the calibration word at 0xC has these fields:
  - bits 23:0 hold REF_HZ/100 − 1, truncated to 24 bits;
  - bit 30 is 1 when REF_HZ is not a multiple of 100;
  - bit 31 is 0.
- R9: Without a reference, the calibration word reads 0x8000_0000, and control bit 2 reads 1 after any control write.
- R10: The reload register stores 24 bits; bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Single-cycle reference tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench goes after several corner cases, each of which a faulty design would get visibly wrong:
- A zero reload: a faulty design would wrap the counter to all ones instead of staying idle.
- A control read in the same cycle as the one-to-zero tick: a faulty design would lose that event.
- A current-value write: a faulty design would leave a stale flag and interrupt behind.
- Sparse reference strobes: a wrong source select would make the count run at core rate.
- A control write with every bit set: this exposes stray stored bits.

Three build variants are used:
- A 1 MHz reference, to check an exact calibration count.
- A 32768 Hz reference, to check the skew flag.
- A build without a reference, to check the no-reference calibration word and the forced source bit.

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
  parameter int          CNT_W   = 24,
  parameter int unsigned REF_HZ  = 1_000_000,
  parameter bit          HAS_REF = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_tick_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam logic              FORCE_CORE = !HAS_REF;
  localparam int unsigned       TEN_MS     = REF_HZ / 100;
  localparam logic [31:0]       CAL_TICKS  = 32'(TEN_MS - 1);
  localparam logic              SKEW       = (REF_HZ % 100) != 0;
  localparam logic [31:0]       CAL_WORD   = HAS_REF ? {1'b0, SKEW, 6'b0, CAL_TICKS[23:0]}
                                                     : 32'h8000_0000;
  localparam logic [CNT_W-1:0]  ONE        = 1;

  logic [2:0]       ctrl_q;
  logic [CNT_W-1:0] rel_q, cur_q;
  logic             flag_q;

  wire ctrl_wr  = wr_en_i && addr_i == 4'h0;
  wire rel_wr   = wr_en_i && addr_i == 4'h4;
  wire cur_wr   = wr_en_i && addr_i == 4'h8;
  wire ctrl_rd  = rd_en_i && addr_i == 4'h0;
  wire tick     = ctrl_q[0] && (ctrl_q[2] || ref_tick_i);
  wire hit_zero = tick && cur_q == ONE;
  wire unused_w = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= {FORCE_CORE, 2'b00};
    else if (ctrl_wr) ctrl_q <= wdata_i[2:0] | {FORCE_CORE, 2'b00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rel_q <= '0;
    else if (rel_wr) rel_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (cur_wr) cur_q <= '0;
    else if (tick)   cur_q <= (cur_q == '0) ? rel_q : cur_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (cur_wr)   flag_q <= 1'b0;
    else if (hit_zero) flag_q <= 1'b1;
    else if (ctrl_rd)  flag_q <= 1'b0;
  end

  always_comb begin
    case (addr_i)
      4'h0:    rdata_o = {15'b0, flag_q, 13'b0, ctrl_q};
      4'h4:    rdata_o = 32'(rel_q);
      4'h8:    rdata_o = 32'(cur_q);
      4'hC:    rdata_o = CAL_WORD;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & ctrl_q[1];

  p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cur_q != '0 && !cur_wr |=> cur_q == $past(cur_q) - ONE);
  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !cur_wr |=> $stable(cur_q));
  p_reload_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cur_q == '0 && !cur_wr |=> cur_q == $past(rel_q));
  p_flag_on_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_zero && !cur_wr |=> flag_q);
  p_cur_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_wr |=> cur_q == '0 && !flag_q);

  if (!HAS_REF) begin : g_no_ref
    p_core_forced_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_q[2]);
  end
endmodule

// File: tb/tick_down_timer_tb.sv
module tick_down_timer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_skew, rdata_noref;
  logic        irq, irq_skew, irq_noref;

  int checks = 0, fails = 0, irq_seen = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tick_down_timer dut_i (.clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq));
  tick_down_timer #(.REF_HZ(32768)) skew_i (.clk_i(clk), .rst_ni(rst_n),
    .ref_tick_i(ref_tick), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_skew), .irq_o(irq_skew));
  tick_down_timer #(.REF_HZ(32768), .HAS_REF(1'b0)) noref_i (.clk_i(clk),
    .rst_ni(rst_n), .ref_tick_i(ref_tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_noref), .irq_o(irq_noref));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int unsigned m_ctrl = 0, m_rel = 0, m_cur = 0;
  bit m_flag = 0;

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'h0: return (32'(m_flag) << 16) | 32'(m_ctrl);
      4'h4: return 32'(m_rel);
      4'h8: return 32'(m_cur);
      4'hC: return 32'd9999;
      default: return 32'd0;
    endcase
  endfunction

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_ctrl = 0; m_rel = 0; m_cur = 0; m_flag = 0;
    end else begin
      automatic bit tk = m_ctrl[0] && (m_ctrl[2] || ref_tick);
      automatic int unsigned nc = m_cur;
      automatic bit nf = m_flag;
      if (rd_en && addr == 4'h0) nf = 0;
      if (tk) begin
        if (m_cur == 0) nc = m_rel;
        else begin
          nc = m_cur - 1;
          if (m_cur == 1) nf = 1;
        end
      end
      if (wr_en) begin
        case (addr)
          4'h0: m_ctrl = wdata & 32'h7;
          4'h4: m_rel = wdata & 32'h00FF_FFFF;
          4'h8: begin nc = 0; nf = 0; end
          default: ;
        endcase
      end
      m_cur = nc; m_flag = nf;
    end
    #(CLK_P/4);
    if (rst_n) begin
      chk("R3 cycle rdata", rdata, m_read(addr));
      chk("R5 cycle irq", 32'(irq), 32'(m_flag && m_ctrl[1]));
      if (irq) irq_seen++;
    end
  end

  task automatic drive(bit w, bit r, logic [3:0] a, logic [31:0] d, bit t = 0);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; ref_tick = t;
  endtask

  task automatic peek(logic [3:0] a);
    drive(0, 0, a, 0);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(4'h0); chk("R1 ctrl reset", rdata, 32'h0); chk("R1 irq reset", 32'(irq), 0);
    chk("R9 noref ctrl reset", rdata_noref, 32'h4);
    peek(4'h4); chk("R1 reload reset", rdata, 32'h0);
    peek(4'h8); chk("R1 current reset", rdata, 32'h0);
    peek(4'hC); chk("R8 calib exact", rdata, 32'h0000_270F);
    chk("R8 calib skew", rdata_skew, 32'h4000_0146);
    chk("R9 calib noref", rdata_noref, 32'h8000_0000);

    drive(1, 0, 4'h4, 32'hFFFF_FFFF);
    peek(4'h4); chk("R10 reload width", rdata, 32'h00FF_FFFF);

    drive(1, 0, 4'h0, 32'hFFFF_FFFE);
    peek(4'h0); chk("R2 ctrl mask", rdata & 32'hFFFE_FFFF, 32'h6);

    // zero reload stays idle
    drive(1, 0, 4'h4, 32'h0);
    drive(1, 0, 4'h0, 32'h5);
    repeat (6) peek(4'h8);
    chk("R4 zero reload idle", rdata, 32'h0);

    // periodic core-clock counting with interrupt
    drive(1, 0, 4'h4, 32'd5);
    drive(1, 0, 4'h0, 32'h7);
    repeat (20) peek(4'h8);
    chk("R5 irq raised", 32'(irq_seen > 0), 32'd1);
    drive(0, 1, 4'h0, 0);
    repeat (10) peek(4'h0);

    // reference-tick source
    drive(1, 0, 4'h0, 32'h1);
    for (int i = 0; i < 60; i++) drive(0, 0, 4'h8, 0, bit'($urandom_range(0, 3) == 0));
    drive(1, 0, 4'h8, 32'hDEAD_BEEF);
    peek(4'h8); chk("R7 current cleared", rdata, 32'h0);
    peek(4'h0); chk("R7 flag cleared", rdata & 32'h0001_0000, 32'h0);

    // disable and hold
    drive(1, 0, 4'h0, 32'h0);
    peek(4'h0); chk("R9 noref src forced", rdata_noref & 32'h7, 32'h4);
    drive(1, 0, 4'h4, 32'd3);
    repeat (5) peek(4'h8);
    chk("R3 disabled hold", rdata, 32'h0);

    // flag set and control read in the same cycle
    drive(1, 0, 4'h0, 32'h5);
    peek(4'h8); peek(4'h8); peek(4'h8);
    drive(0, 1, 4'h0, 0);
    peek(4'h0); chk("R6 set wins over read", rdata & 32'h0001_0000, 32'h0001_0000);
    drive(0, 1, 4'h0, 0);
    peek(4'h0); chk("R6 read clears flag", rdata & 32'h0001_0000, 32'h0);
    repeat (12) peek(4'h8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule